// File: doc/BRIEF.md
# Transmit FIFO Free-Space Trigger Interrupt

This block holds outgoing UART characters in a 64-entry byte queue and raises a transmit-ready interrupt when enough of that queue is free. Host software loads bytes through a holding-register write port. A downstream serializer takes one byte per character time through a pop interface. The block reports the current free-space count so the host can see how much it may write. The interrupt gives the host a refill window that depends on where the trigger threshold is set.

The threshold has two sources. A fine trigger register has a transmit nibble that gives the threshold in steps of four free locations. When that nibble is zero, a coarse two-bit code in the FIFO control register applies instead. The same fine register has a receive nibble, which is passed out unchanged for the receive path. The fine register can only be written while an enable bit in the modem control register is set. After reset the fine register is zero, so the coarse default of 8 free locations applies.

Configuration uses a 2-bit address: 0 is interrupt enable, 1 is FIFO control, 2 is modem control, 3 is the fine trigger register.

Top module: `txfill_top`

## Requirements
- R1: The queue holds 64 bytes and pops them in write order. `tx_space` reports the free locations, from 0 to 64. It changes only when a write is accepted or a pop is taken.
- R2: A holding-register write while `tx_space` is 0 is dropped. This includes a write in the same cycle as a pop while full: the pop is taken and `tx_space` becomes 1.
- R3: A pop while `tx_space` is 64 changes nothing in the queue. `underrun` goes high in the next cycle, for one cycle.
- R4: A write and a pop in the same cycle on a queue that is neither full nor empty leave `tx_space` unchanged.
- R5: When bits 3:0 of the fine register (address 3) are nonzero, the threshold is four times that value.
- R6: When bits 3:0 of the fine register are zero, FIFO control (address 1) bits 5:4 choose the threshold: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56.
- R7: Bits 7:4 of the fine register appear on `rx_trig` and have no effect on the transmit threshold.
- R8: A write to address 3 updates the fine register only while modem control (address 2) bit 2 is 1. At other times it is ignored.
- R9: Synchronous reset sets `tx_space` to 64 and the threshold to 8, and sets `irq`, `rx_trig`, `underrun` and `pop_valid` to 0.
- R10: `irq` is high exactly when interrupt enable (address 0) bit 1 is set and `tx_space` is at least the threshold. It drops when a write takes the space below the threshold, and it rises again when a pop brings the space back to the threshold.
- R11: When interrupt enable bit 1 is cleared, `irq` goes low even while the space is above the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| thr_we | input | 1 | Holding-register byte write |
| thr_data | input | 8 | Byte to queue |
| pop | input | 1 | Serializer takes the head byte |
| pop_data | output | 8 | Head byte of the queue |
| pop_valid | output | 1 | Queue is not empty |
| tx_space | output | 7 | Free locations, 0 to 64 |
| tx_thresh | output | 7 | Threshold currently in force |
| rx_trig | output | 4 | Receive nibble of the fine register |
| underrun | output | 1 | One-cycle flag after a pop on an empty queue |
| irq | output | 1 | Transmit-ready interrupt |

## Verification
The bench walks all four coarse codes with the fine nibble at zero. A design that ignored the fallback, or decoded the codes wrongly, would report the wrong `tx_thresh` and a wrong `irq` at 32 free locations.

It writes the fine register while the modem enable bit is clear. A design without the lock would show a changed threshold or a changed `rx_trig`.

It steps the space across the threshold in both directions by exactly one byte, which catches a compare that is off by one. It also pushes into a full queue, both alone and in the same cycle as a pop, and pops an empty queue. A faulty queue would show a wrapped count, corrupted byte order, or a missing or stuck underrun flag.

// File: rtl/txfill_pkg.sv
`timescale 1ns/1ps
package txfill_pkg;
    localparam int TXF_DEPTH = 64;
    localparam int TXF_DW    = 8;
    localparam int TXF_LW    = $clog2(TXF_DEPTH + 1);

    typedef enum logic [1:0] {
        RA_INTEN   = 2'd0,
        RA_FIFOCTL = 2'd1,
        RA_MODEM   = 2'd2,
        RA_TRIGLVL = 2'd3
    } regaddr_e;

    localparam int IE_TXRDY_BIT     = 1;
    localparam int FC_TXCODE_LO     = 4;
    localparam int MODEM_TRIGEN_BIT = 2;

    typedef struct packed {
        logic       txrdy_en;
        logic [1:0] fc_code;
        logic       trig_open;
        logic [3:0] fine_tx;
        logic [3:0] fine_rx;
    } txcfg_t;

    // Fine nibble in steps of four; zero falls back to the coarse code.
    function automatic logic [TXF_LW-1:0] pick_thresh(input logic [3:0] fine,
                                                      input logic [1:0] code);
        logic [TXF_LW-1:0] r;
        if (fine != 4'd0) begin
            r = TXF_LW'({fine, 2'b00});
        end else begin
            case (code)
                2'd0:    r = TXF_LW'(8);
                2'd1:    r = TXF_LW'(16);
                2'd2:    r = TXF_LW'(32);
                default: r = TXF_LW'(56);
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/txfill_regs.sv
`timescale 1ns/1ps
module txfill_regs
    import txfill_pkg::*;
#(
    parameter int LW = TXF_LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [7:0]    wdata,
    output txcfg_t        cfg,
    output logic [LW-1:0] thresh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (regaddr_e'(addr))
                RA_INTEN:   cfg.txrdy_en  <= wdata[IE_TXRDY_BIT];
                RA_FIFOCTL: cfg.fc_code   <= wdata[FC_TXCODE_LO +: 2];
                RA_MODEM:   cfg.trig_open <= wdata[MODEM_TRIGEN_BIT];
                RA_TRIGLVL: begin
                    if (cfg.trig_open) begin
                        cfg.fine_tx <= wdata[3:0];
                        cfg.fine_rx <= wdata[7:4];
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb thresh = LW'(pick_thresh(cfg.fine_tx, cfg.fc_code));
endmodule

// File: rtl/txfill_store.sv
`timescale 1ns/1ps
module txfill_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          nonempty,
    output logic [LW-1:0] space,
    output logic          underrun
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (space == '0);
        empty   = (space == LW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            space    <= LW'(DEPTH);
            underrun <= 1'b0;
        end else begin
            underrun <= pop && empty;
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   space <= space - 1'b1;
                2'b01:   space <= space + 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_comb begin
        head_data = mem[rptr];
        nonempty  = !empty;
    end
endmodule

// File: rtl/txfill_top.sv
`timescale 1ns/1ps
module txfill_top
    import txfill_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              thr_we,
    input  logic [TXF_DW-1:0] thr_data,
    input  logic              pop,
    output logic [TXF_DW-1:0] pop_data,
    output logic              pop_valid,
    output logic [TXF_LW-1:0] tx_space,
    output logic [TXF_LW-1:0] tx_thresh,
    output logic [3:0]        rx_trig,
    output logic              underrun,
    output logic              irq
);
    txcfg_t cfg;
    logic   trig_open;

    txfill_regs #(.LW(TXF_LW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .cfg    (cfg),
        .thresh (tx_thresh)
    );

    txfill_store #(.DEPTH(TXF_DEPTH), .DW(TXF_DW), .LW(TXF_LW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (thr_we),
        .push_data (thr_data),
        .pop       (pop),
        .head_data (pop_data),
        .nonempty  (pop_valid),
        .space     (tx_space),
        .underrun  (underrun)
    );

    always_comb begin
        trig_open = cfg.trig_open;
        rx_trig   = cfg.fine_rx;
        irq       = cfg.txrdy_en && (tx_space >= tx_thresh);
    end
endmodule

// File: rtl/txfill_chk.sv
`timescale 1ns/1ps
module txfill_chk #(
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [1:0]    cfg_addr,
    input logic          thr_we,
    input logic          pop,
    input logic [LW-1:0] tx_space,
    input logic [LW-1:0] tx_thresh,
    input logic [3:0]    rx_trig,
    input logic          underrun,
    input logic          irq,
    input logic          trig_open
);
    assert_space_bound_R1: assert property (@(posedge clk) disable iff (rst)
        tx_space <= LW'(DEPTH));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!thr_we && !pop) |=> $stable(tx_space));

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_space == '0 && thr_we && !pop) |=> (tx_space == '0));

    assert_underrun_set_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && tx_space == LW'(DEPTH)) |=> underrun);

    assert_underrun_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !(pop && tx_space == LW'(DEPTH)) |=> !underrun);

    assert_pair_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (thr_we && pop && tx_space != '0 && tx_space != LW'(DEPTH)) |=> $stable(tx_space));

    assert_thresh_legal_R5: assert property (@(posedge clk) disable iff (rst)
        tx_thresh[1:0] == 2'b00 && tx_thresh != '0 && tx_thresh < LW'(DEPTH));

    assert_trig_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd3 && !trig_open) |=> ($stable(rx_trig) && $stable(tx_thresh)));

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (thr_we && !pop && !cfg_we && tx_space == tx_thresh) |=> !irq);
endmodule

bind txfill_top txfill_chk #(.DEPTH(txfill_pkg::TXF_DEPTH), .LW(txfill_pkg::TXF_LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .thr_we    (thr_we),
    .pop       (pop),
    .tx_space  (tx_space),
    .tx_thresh (tx_thresh),
    .rx_trig   (rx_trig),
    .underrun  (underrun),
    .irq       (irq),
    .trig_open (trig_open)
);

// File: tb/sim_txfill_top.sv
`timescale 1ns/1ps
module sim_txfill_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       pop_valid;
    logic [6:0] tx_space;
    logic [6:0] tx_thresh;
    logic [3:0] rx_trig;
    logic       underrun;
    logic       irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] model [$];

    txfill_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .thr_we(thr_we), .thr_data(thr_data), .pop(pop),
        .pop_data(pop_data), .pop_valid(pop_valid), .tx_space(tx_space),
        .tx_thresh(tx_thresh), .rx_trig(rx_trig), .underrun(underrun), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [1:0] op;    // 0 cfg write, 1 byte write, 2 pop
        logic [1:0] addr;
        logic [7:0] data;
        logic [6:0] esp;
        logic [6:0] eth;
        logic       eirq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd0, 8'h02, 7'd64, 7'd8,  1'b1},  // R10 enable
        '{2'd0, 2'd3, 8'h08, 7'd64, 7'd8,  1'b1},  // R8 locked write
        '{2'd0, 2'd2, 8'h04, 7'd64, 7'd8,  1'b1},  // R8 open
        '{2'd0, 2'd3, 8'h58, 7'd64, 7'd32, 1'b1},  // R5 fine 8 -> 32
        '{2'd0, 2'd2, 8'h00, 7'd64, 7'd32, 1'b1},  // R8 close
        '{2'd0, 2'd3, 8'h03, 7'd64, 7'd32, 1'b1},  // R8 locked write
        '{2'd1, 2'd0, 8'hA1, 7'd63, 7'd32, 1'b1},  // R1 write
        '{2'd1, 2'd0, 8'hA2, 7'd62, 7'd32, 1'b1},  // R1 write
        '{2'd2, 2'd0, 8'h00, 7'd63, 7'd32, 1'b1}   // R1 pop
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit cw, input logic [1:0] a, input logic [7:0] d,
                       input bit tw, input logic [7:0] td, input bit pp);
        bit full_pre;
        @(negedge clk);
        cfg_we = cw; cfg_addr = a; cfg_wdata = d;
        thr_we = tw; thr_data = td; pop = pp;
        full_pre = (model.size() == 64);
        if (pp && model.size() > 0) begin
            chk("R1 pop order", int'(pop_data), int'(model[0]));
            void'(model.pop_front());
        end
        if (tw && !full_pre) model.push_back(td);
        @(posedge clk);
        #1;
        cfg_we = 1'b0; thr_we = 1'b0; pop = 1'b0;
    endtask

    task automatic cfgw(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [7:0] td);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, td, 1'b0);
    endtask

    task automatic pp1();
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        chk("R9 reset space", tx_space, 64);
        chk("R9 reset thresh", tx_thresh, 8);
        chk("R9 reset irq", irq, 0);
        chk("R9 reset rx_trig", rx_trig, 0);
        chk("R9 reset underrun", underrun, 0);
        chk("R9 reset pop_valid", pop_valid, 0);

        for (int i = 0; i < NV; i++) begin
            cyc(VT[i].op == 2'd0, VT[i].addr, VT[i].data,
                VT[i].op == 2'd1, VT[i].data, VT[i].op == 2'd2);
            chk("R1 vector space", tx_space, VT[i].esp);
            chk("R5 R6 R8 vector thresh", tx_thresh, VT[i].eth);
            chk("R10 vector irq", irq, VT[i].eirq);
        end
        chk("R7 R8 rx nibble kept while locked", rx_trig, 5);

        // threshold crossing, one byte at a time
        for (int i = 0; i < 31; i++) wr(8'h10 + 8'(i));
        chk("R10 space at threshold", tx_space, 32);
        chk("R10 irq at threshold", irq, 1);
        wr(8'h40);
        chk("R10 irq clears below threshold", irq, 0);
        pp1();
        chk("R10 irq back at threshold", irq, 1);

        // coarse fallback codes
        cfgw(2'd2, 8'h04);
        cfgw(2'd3, 8'h50);
        chk("R6 code 00", tx_thresh, 8);
        chk("R7 rx nibble", rx_trig, 5);
        cfgw(2'd1, 8'h30);
        chk("R6 code 11", tx_thresh, 56);
        chk("R10 irq below 56", irq, 0);
        cfgw(2'd1, 8'h10);
        chk("R6 code 01", tx_thresh, 16);
        cfgw(2'd1, 8'h20);
        chk("R6 code 10", tx_thresh, 32);
        chk("R10 irq at 32", irq, 1);
        cfgw(2'd1, 8'h00);
        chk("R6 code back to 00", tx_thresh, 8);
        cfgw(2'd3, 8'h5F);
        chk("R5 fine 15", tx_thresh, 60);
        chk("R7 rx unchanged by tx nibble", rx_trig, 5);
        cfgw(2'd3, 8'h08);
        chk("R5 fine 8", tx_thresh, 32);
        chk("R7 rx zero", rx_trig, 0);
        cfgw(2'd2, 8'h00);
        cfgw(2'd3, 8'h91);
        chk("R8 locked thresh", tx_thresh, 32);
        chk("R8 locked rx", rx_trig, 0);

        // full queue
        for (int i = 0; i < 32; i++) wr(8'h80 + 8'(i));
        chk("R1 full space", tx_space, 0);
        wr(8'hEE);
        chk("R2 write on full dropped", tx_space, 0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'hEF, 1'b1);
        chk("R2 write with pop on full", tx_space, 1);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'hC3, 1'b1);
        chk("R4 write with pop", tx_space, 1);
        while (model.size() > 0) pp1();
        chk("R1 drained space", tx_space, 64);
        chk("R3 no underrun on normal pop", underrun, 0);
        chk("R10 irq empty", irq, 1);
        pp1();
        chk("R3 underrun pulse", underrun, 1);
        chk("R3 space unchanged", tx_space, 64);
        chk("R3 pop_valid stays low", pop_valid, 0);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0);
        chk("R3 underrun one cycle", underrun, 0);

        cfgw(2'd0, 8'h00);
        chk("R11 irq masked", irq, 0);

        // reset mid-run
        cfgw(2'd2, 8'h04);
        cfgw(2'd3, 8'h7C);
        wr(8'h55);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        model.delete();
        @(posedge clk); #1;
        chk("R9 space after reset", tx_space, 64);
        chk("R9 thresh after reset", tx_thresh, 8);
        chk("R9 rx after reset", rx_trig, 0);
        chk("R9 irq after reset", irq, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule